// File: doc/BRIEF.md
# Configurable Input Macrocell Array

This block conditions a set of port input pins before they reach a programmable logic array. There are twenty cells: eight for the first port, eight for the second and four for the third. Each cell takes one pin and drives one bit of the logic input bus. Software or configuration logic sets each cell on its own to one of four behaviours. It can pass the pin straight through. It can capture the pin on a rising strobe edge. It can act as a level-sensitive latch on a strobe. It can latch on the processor's address-latch-enable strobe.

The capture strobes are shared. Each group of four consecutive cells has one strobe, so a port of eight pins uses two strobes, one for pins 0 to 3 and one for pins 4 to 7. All cells sit in one clock domain. Strobe edges and levels are sampled on the system clock, and each cell's output is a register. A host read port shows the conditioned values of one port at a time, with no clock delay.

Top module: `imc_array`

## Requirements
- R1: A synchronous active-high reset clears every cell output to 0. It also clears the stored previous level of every group strobe to 0.
- R2: In mode 00 (pass), a cell's bus output equals its pin as sampled at the previous clock edge.
- R3: In mode 01 (edge capture), a cell loads its pin only at a clock edge where its group strobe is 1 and was 0 at the edge before. At every other edge it holds its value.
- R4: In mode 10 (gated latch), a cell loads its pin at every clock edge where its group strobe is 1. It holds its value while that strobe is 0.
- R5: In mode 11 (ALE latch), a cell loads its pin at every clock edge where `ale_i` is 1 and ignores its group strobe.
- R6: Strobe bit g serves only cells 4g to 4g+3, so a strobe never changes a cell outside its group.
- R7: When a cell's mode changes, it keeps its current value until the capture condition of the new mode occurs.
- R8: The read port is combinational. It returns the current cell outputs selected by `rd_sel_i`. Code 00 gives cells 0 to 7 and code 01 gives cells 8 to 15, each with the lower cell in bit 0. Code 10 gives cells 16 to 19 in bits 3 to 0 and 0 in bits 7 to 4. Code 11 gives all zeros.
- R9: The mode of cell i is bits 2i+1 and 2i of `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 20 | Pin inputs, ports in order first, second, third |
| mode_i | input | 40 | Two mode bits per cell |
| strobe_i | input | 5 | One shared clock or gate strobe per group of four cells |
| ale_i | input | 1 | Processor address-latch-enable strobe |
| bus_o | output | 20 | Conditioned values to the logic input bus |
| rd_sel_i | input | 2 | Host read port select |
| rd_data_o | output | 8 | Host read data |

## Verification
Each cell holds just one register, and the group strobes hold one stored previous level each. A wrong cell value appears on `bus_o` at the next clock edge. It also appears on the read port in that same cycle. A wrong stored strobe level shows up at the next strobe edge, where a capture happens one cycle early, one cycle late, or not at all. A cell that tracks its pin while it should hold shows up at the first pin change after the strobe goes low. The reference model is therefore compared on every cycle, with random pins and strobes in every mode.

// File: rtl/imc_pkg.sv
package imc_pkg;
  typedef enum logic [1:0] {
    IMC_PASS    = 2'b00,
    IMC_CLOCKED = 2'b01,
    IMC_GATED   = 2'b10,
    IMC_ALE     = 2'b11
  } imc_mode_e;
endpackage

// File: rtl/imc_edge.sv
// Rising-edge detection for the shared group strobes, sampled on clk.
module imc_edge #(
  parameter int NGRP = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGRP-1:0] strobe_i,
  output logic [NGRP-1:0] rise_o
);
  logic [NGRP-1:0] strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= '0;
    else     strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/imc_cell.sv
// One conditioning cell: a single register with a mode-selected load enable.
module imc_cell
  import imc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  input  logic       rise_i,
  input  logic       gate_i,
  input  logic       ale_i,
  output logic       q_o
);
  imc_mode_e mode;
  logic      load;

  assign mode = imc_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      IMC_PASS:    load = 1'b1;
      IMC_CLOCKED: load = rise_i;
      IMC_GATED:   load = gate_i;
      IMC_ALE:     load = ale_i;
      default:     load = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       q_o <= 1'b0;
    else if (load) q_o <= pin_i;
  end
endmodule

// File: rtl/imc_rdmux.sv
// Host read selection: one port per select code, zero-extended.
module imc_rdmux #(
  parameter int N_A  = 8,
  parameter int N_B  = 8,
  parameter int N_C  = 4,
  parameter int RD_W = 8,
  localparam int NCELL = N_A + N_B + N_C
) (
  input  logic [NCELL-1:0] cells_i,
  input  logic [1:0]       sel_i,
  output logic [RD_W-1:0]  data_o
);
  always_comb begin
    data_o = '0;
    case (sel_i)
      2'd0:    data_o[N_A-1:0] = cells_i[0 +: N_A];
      2'd1:    data_o[N_B-1:0] = cells_i[N_A +: N_B];
      2'd2:    data_o[N_C-1:0] = cells_i[N_A+N_B +: N_C];
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/imc_array.sv
// Array of input conditioning cells; port sizes must be multiples of GRP.
module imc_array #(
  parameter int N_A  = 8,
  parameter int N_B  = 8,
  parameter int N_C  = 4,
  parameter int GRP  = 4,
  parameter int RD_W = 8,
  localparam int NCELL = N_A + N_B + N_C,
  localparam int NGRP  = NCELL / GRP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCELL-1:0]   pin_i,
  input  logic [2*NCELL-1:0] mode_i,
  input  logic [NGRP-1:0]    strobe_i,
  input  logic               ale_i,
  output logic [NCELL-1:0]   bus_o,
  input  logic [1:0]         rd_sel_i,
  output logic [RD_W-1:0]    rd_data_o
);
  logic [NGRP-1:0] rise;

  imc_edge #(.NGRP(NGRP)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .rise_o   (rise)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    localparam int G = i / GRP;
    imc_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[i]),
      .mode_i (mode_i[2*i +: 2]),
      .rise_i (rise[G]),
      .gate_i (strobe_i[G]),
      .ale_i  (ale_i),
      .q_o    (bus_o[i])
    );
  end

  imc_rdmux #(.N_A(N_A), .N_B(N_B), .N_C(N_C), .RD_W(RD_W)) u_rd (
    .cells_i (bus_o),
    .sel_i   (rd_sel_i),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/imc_array_chk.sv
module imc_array_chk #(
  parameter int NCELL = 20,
  parameter int GRP   = 4,
  parameter int N_C   = 4,
  parameter int RD_W  = 8,
  localparam int NGRP = NCELL / GRP
) (
  input logic               clk,
  input logic               rst,
  input logic [NCELL-1:0]   pin_i,
  input logic [2*NCELL-1:0] mode_i,
  input logic [NGRP-1:0]    strobe_i,
  input logic               ale_i,
  input logic [NCELL-1:0]   bus_o,
  input logic [1:0]         rd_sel_i,
  input logic [RD_W-1:0]    rd_data_o
);
  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    localparam int G = i / GRP;
    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode_i[2*i +: 2]) == 2'b00) |-> bus_o[i] == $past(pin_i[i])); // R2
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode_i[2*i +: 2]) == 2'b01 && !$past(strobe_i[G])) |-> $stable(bus_o[i])); // R3
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode_i[2*i +: 2]) == 2'b10 && !$past(strobe_i[G])) |-> $stable(bus_o[i])); // R4
    AST_ALE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mode_i[2*i +: 2]) == 2'b11 && $past(ale_i)) |-> bus_o[i] == $past(pin_i[i])); // R5
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_i == 2'b10) |-> rd_data_o[RD_W-1:N_C] == '0); // R8
endmodule

bind imc_array imc_array_chk #(.NCELL(NCELL), .GRP(GRP), .N_C(N_C), .RD_W(RD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_i     (pin_i),
  .mode_i    (mode_i),
  .strobe_i  (strobe_i),
  .ale_i     (ale_i),
  .bus_o     (bus_o),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o)
);

// File: tb/tb_imc_array.sv
module tb_imc_array;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 20;
  localparam int NGRP  = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCELL-1:0]  pin;
  logic [2*NCELL-1:0] mode;
  logic [NGRP-1:0]   strobe;
  logic              ale;
  logic [NCELL-1:0]  bus;
  logic [1:0]        rd_sel;
  logic [7:0]        rd_data;

  int checks = 0;
  int failures = 0;
  string phase = "";

  logic [NCELL-1:0] exp_bus;
  logic [NGRP-1:0]  exp_sprev;
  int               used_mode [NCELL];
  logic             rst_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  imc_array dut (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin),
    .mode_i    (mode),
    .strobe_i  (strobe),
    .ale_i     (ale),
    .bus_o     (bus),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data)
  );

  function automatic string req_of(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // One clock: model update at the rising edge, compare at the falling edge.
  task automatic cycle();
    @(posedge clk);
    rst_seen = rst;
    for (int i = 0; i < NCELL; i++) begin
      int m = int'(mode[2*i +: 2]);
      int g = i / 4;
      bit ld;
      used_mode[i] = m;
      case (m)
        0: ld = 1'b1;
        1: ld = strobe[g] && !exp_sprev[g];
        2: ld = strobe[g];
        default: ld = ale;
      endcase
      if (rst) exp_bus[i] = 1'b0;
      else if (ld) exp_bus[i] = pin[i];
    end
    exp_sprev = rst ? '0 : strobe;
    @(negedge clk);
    for (int i = 0; i < NCELL; i++) begin
      checks++;
      if (bus[i] !== exp_bus[i]) begin
        failures++;
        $display("FAIL %s [%s] cell %0d got %b exp %b",
                 rst_seen ? "R1" : req_of(used_mode[i]), phase, i, bus[i], exp_bus[i]);
      end
    end
    begin
      logic [7:0] er;
      case (rd_sel)
        2'd0: er = exp_bus[7:0];
        2'd1: er = exp_bus[15:8];
        2'd2: er = {4'b0, exp_bus[19:16]};
        default: er = 8'h00;
      endcase
      checks++;
      if (rd_data !== er) begin
        failures++;
        $display("FAIL R8 [%s] sel %0d got %h exp %h", phase, rd_sel, rd_data, er);
      end
    end
  endtask

  task automatic set_all_modes(int m);
    for (int i = 0; i < NCELL; i++) mode[2*i +: 2] = 2'(m);
  endtask

  task automatic rand_io();
    pin    = NCELL'($urandom());
    strobe = NGRP'($urandom());
    ale    = 1'($urandom());
    rd_sel = 2'($urandom());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    exp_bus = '0; exp_sprev = '0;
    rst = 1'b1; pin = '1; mode = '0; strobe = '1; ale = 1'b1; rd_sel = 2'd0;
    phase = "R1 reset";
    for (int k = 0; k < 3; k++) begin rd_sel = 2'(k); cycle(); end
    rst = 1'b0;

    phase = "R2 pass R9";
    set_all_modes(0);
    for (int k = 0; k < 30; k++) begin rand_io(); cycle(); end

    phase = "R3 edge capture";
    set_all_modes(1);
    for (int k = 0; k < 60; k++) begin rand_io(); cycle(); end

    phase = "R4 gated latch";
    set_all_modes(2);
    for (int k = 0; k < 60; k++) begin rand_io(); cycle(); end

    phase = "R5 ale latch";
    set_all_modes(3);
    for (int k = 0; k < 60; k++) begin rand_io(); cycle(); end

    // R6: one strobe toggles at a time; other groups must keep their values.
    phase = "R6 group isolation";
    for (int g = 0; g < NGRP; g++) begin
      for (int k = 0; k < 8; k++) begin
        set_all_modes((k < 4) ? 1 : 2);
        pin = NCELL'($urandom());
        strobe = '0;
        strobe[g] = k[0];
        ale = 1'b1;
        rd_sel = 2'($urandom());
        cycle();
      end
    end

    // R7 and R9: per-cell random modes changing every cycle.
    phase = "R7 mode change R9";
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      mode = r[2*NCELL-1:0];
      rand_io();
      cycle();
    end

    phase = "R1 mid-run reset";
    rst = 1'b1; rand_io(); cycle();
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin rand_io(); cycle(); end

    summary();
    $finish;
  end
endmodule